// File: doc/BRIEF.md
# Debug Coprocessor Register Bank

This block is a small debug register bank that the core reaches through a coprocessor-style access port. Each access carries four selector fields (a 3-bit first opcode, a 4-bit primary register number, a 4-bit secondary register number and a 3-bit second opcode), a direction bit, a privilege flag and 32-bit write data. Read data and an undefined-access indication come back on the clock edge after the access.

The bank holds a crossed pair of 32-bit transfer registers that carry words between the core and an external debugger. The transfer direction flips between the two sides. A core write fills the outbound register, and the debugger consumes it. The debugger fills the inbound register, and a core read consumes it. Each register has a full flag and a sticky overrun flag. A third register holds the address of the instruction that set off a watchpoint. It is loaded from a watchpoint event, with an offset that depends on the instruction-set state the core was in. Privileged software can also read and write it.

Top module: `dbg_cop_regs`

## Requirements
- R1: Every selector match needs first opcode 0, primary register number 0 and second opcode 0. A secondary register number of 5 selects the transfer pair, and 6 selects the watchpoint address register. Read data and the undefined indication for an access appear on the rising edge after the access cycle.
- R2: A core write (cp_write=1) to the transfer selector while the outbound register is empty loads cp_wdata into it, so that it shows on ext_tx_data, and sets tx_full.
- R3: A core read (cp_write=0) of the transfer selector returns the inbound register on cp_rdata and clears rx_full.
- R4: An external write (ext_rx_wr) while the inbound register is empty loads ext_rx_data and sets rx_full. An external read (ext_tx_rd) clears tx_full.
- R5: A write to a transfer register whose full flag is already set is ignored. It leaves the held word unchanged and sets that side's overrun flag, which stays set until reset.
- R6: A privileged access to the watchpoint address register writes it from cp_wdata or reads it back on cp_rdata.
- R7: An unprivileged access to the watchpoint address register returns zero, leaves the register unchanged and asserts cp_undef for that one response cycle.
- R8: On wp_hit the watchpoint address register loads wp_pc plus an offset chosen by isa_state: 00 gives +8, 01 gives +4, 10 gives +0, and 11 gives +8.
- R9: When wp_hit and a privileged software write to the watchpoint address register occur in the same cycle, the watchpoint capture wins.
- R10: abort_evt has no effect on the watchpoint address register.
- R11: An access whose selector fields match neither register returns zero and asserts cp_undef.
- R12: While in reset, and until the first access, rx_full, tx_full, both overrun flags, cp_undef and cp_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_valid | input | 1 | Core access strobe |
| cp_write | input | 1 | 1 = core writes, 0 = core reads |
| cp_op1 | input | 3 | First opcode selector |
| cp_crn | input | 4 | Primary register number |
| cp_crm | input | 4 | Secondary register number |
| cp_op2 | input | 3 | Second opcode selector |
| cp_priv | input | 1 | Core is in a privileged mode |
| cp_wdata | input | 32 | Core write data |
| cp_rdata | output | 32 | Core read data, one cycle after access |
| cp_undef | output | 1 | Undefined access, one cycle after access |
| ext_rx_wr | input | 1 | Debugger writes the inbound register |
| ext_rx_data | input | 32 | Debugger write data |
| ext_tx_rd | input | 1 | Debugger consumes the outbound register |
| ext_tx_data | output | 32 | Outbound register contents |
| rx_full | output | 1 | Inbound register holds unread data |
| tx_full | output | 1 | Outbound register holds unread data |
| rx_ovr | output | 1 | Sticky inbound overrun |
| tx_ovr | output | 1 | Sticky outbound overrun |
| wp_hit | input | 1 | Watchpoint fired this cycle |
| wp_pc | input | 32 | Address of the faulting instruction |
| isa_state | input | 2 | Instruction-set state code |
| abort_evt | input | 1 | Precise abort occurred this cycle |

## Verification
Every result is due exactly one rising edge after its cause: cp_rdata and cp_undef for an access, the flags and ext_tx_data for a transfer-side event, and the watchpoint register contents, which the bench reads through a later privileged access. The bench drives inputs and samples outputs on the falling edge. Each cycle it advances a reference model by one step from the inputs it just applied, then compares all outputs at the next falling edge. It therefore never looks at a value one cycle early or late. Words whose value is still undefined after reset are compared only once the model has seen them loaded.

// File: rtl/dbg_cop_pkg.sv
package dbg_cop_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP1_W  = 3;
  localparam int unsigned CRN_W  = 4;
  localparam int unsigned CRM_W  = 4;
  localparam int unsigned OP2_W  = 3;

  localparam logic [CRM_W-1:0] CRM_XFER = 4'd5;
  localparam logic [CRM_W-1:0] CRM_WFAR = 4'd6;

  typedef enum logic [1:0] {
    ISA_WORD = 2'b00,
    ISA_HALF = 2'b01,
    ISA_BYTE = 2'b10,
    ISA_RSVD = 2'b11
  } isa_e;

  function automatic logic [DATA_W-1:0] wp_offset(input logic [1:0] isa);
    case (isa)
      ISA_HALF: wp_offset = DATA_W'(4);
      ISA_BYTE: wp_offset = '0;
      default:  wp_offset = DATA_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/dbg_sel_decode.sv
module dbg_sel_decode
  import dbg_cop_pkg::*;
(
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit_xfer,
  output logic             hit_wfar
);
  logic base_ok;

  always_comb begin
    base_ok  = (op1 == '0) && (crn == '0) && (op2 == '0);
    hit_xfer = base_ok && (crm == CRM_XFER);
    hit_wfar = base_ok && (crm == CRM_WFAR);
  end
endmodule

// File: rtl/dbg_xfer_chan.sv
module dbg_xfer_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] data,
  output logic         full,
  output logic         ovr
);
  logic         accept;
  logic         full_d;
  logic         ovr_d;
  logic [W-1:0] data_q;
  logic         full_q;
  logic         ovr_q;

  always_comb begin
    accept = wr_en && !full_q;
    full_d = accept || (full_q && !rd_en);
    ovr_d  = ovr_q || (wr_en && full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) data_q <= wdata;
  end

  assign data = data_q;
  assign full = full_q;
  assign ovr  = ovr_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full) |=> (full && data == $past(wdata)));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ($stable(data) && ovr));

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !full);
endmodule

// File: rtl/dbg_wfar_unit.sv
module dbg_wfar_unit
  import dbg_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_hit,
  input  logic [DATA_W-1:0] wp_pc,
  input  logic [1:0]        isa,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              abort_evt,
  output logic [DATA_W-1:0] wfar
);
  logic              load;
  logic [DATA_W-1:0] wfar_d;
  logic [DATA_W-1:0] wfar_q;

  always_comb begin
    load   = wp_hit || sw_wr;
    wfar_d = wp_hit ? (wp_pc + wp_offset(isa)) : sw_wdata;
  end

  always_ff @(posedge clk) begin
    if (load) wfar_q <= wfar_d;
  end

  assign wfar = wfar_q;

  p_byte_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit && isa == ISA_BYTE) |=> (wfar == $past(wp_pc)));

  p_half_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit && isa == ISA_HALF) |=> (wfar == $past(wp_pc) + DATA_W'(4)));

  p_wp_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit && sw_wr && isa == ISA_WORD) |=> (wfar == $past(wp_pc) + DATA_W'(8)));

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !wp_hit && !sw_wr) |=> $stable(wfar));
endmodule

// File: rtl/dbg_cop_regs.sv
module dbg_cop_regs
  import dbg_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_valid,
  input  logic              cp_write,
  input  logic [OP1_W-1:0]  cp_op1,
  input  logic [CRN_W-1:0]  cp_crn,
  input  logic [CRM_W-1:0]  cp_crm,
  input  logic [OP2_W-1:0]  cp_op2,
  input  logic              cp_priv,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              cp_undef,
  input  logic              ext_rx_wr,
  input  logic [DATA_W-1:0] ext_rx_data,
  input  logic              ext_tx_rd,
  output logic [DATA_W-1:0] ext_tx_data,
  output logic              rx_full,
  output logic              tx_full,
  output logic              rx_ovr,
  output logic              tx_ovr,
  input  logic              wp_hit,
  input  logic [DATA_W-1:0] wp_pc,
  input  logic [1:0]        isa_state,
  input  logic              abort_evt
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_STAGES-1];

  logic              hit_xfer, hit_wfar;
  logic              acc_xfer, acc_wfar_ok;
  logic              core_tx_wr, core_rx_rd, sw_wr, wfar_rd;
  logic [DATA_W-1:0] rx_word, wfar_word;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              undef_d, undef_q;

  dbg_sel_decode u_dec (
    .op1      (cp_op1),
    .crn      (cp_crn),
    .crm      (cp_crm),
    .op2      (cp_op2),
    .hit_xfer (hit_xfer),
    .hit_wfar (hit_wfar)
  );

  always_comb begin
    acc_xfer    = cp_valid && hit_xfer;
    acc_wfar_ok = cp_valid && hit_wfar && cp_priv;
    core_tx_wr  = acc_xfer && cp_write;
    core_rx_rd  = acc_xfer && !cp_write;
    sw_wr       = acc_wfar_ok && cp_write;
    wfar_rd     = acc_wfar_ok && !cp_write;
    undef_d     = cp_valid && !(hit_xfer || (hit_wfar && cp_priv));
    if (core_rx_rd)   rdata_d = rx_word;
    else if (wfar_rd) rdata_d = wfar_word;
    else              rdata_d = '0;
  end

  dbg_xfer_chan #(.W(DATA_W)) u_rx (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (ext_rx_wr),
    .wdata (ext_rx_data),
    .rd_en (core_rx_rd),
    .data  (rx_word),
    .full  (rx_full),
    .ovr   (rx_ovr)
  );

  dbg_xfer_chan #(.W(DATA_W)) u_tx (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (core_tx_wr),
    .wdata (cp_wdata),
    .rd_en (ext_tx_rd),
    .data  (ext_tx_data),
    .full  (tx_full),
    .ovr   (tx_ovr)
  );

  dbg_wfar_unit u_wfar (
    .clk       (clk),
    .rst_n     (srst_n),
    .wp_hit    (wp_hit),
    .wp_pc     (wp_pc),
    .isa       (isa_state),
    .sw_wr     (sw_wr),
    .sw_wdata  (cp_wdata),
    .abort_evt (abort_evt),
    .wfar      (wfar_word)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      undef_q <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      undef_q <= undef_d;
    end
  end

  assign cp_rdata = rdata_q;
  assign cp_undef = undef_q;

  p_undef_zero_r11: assert property (@(posedge clk) disable iff (!srst_n)
    cp_undef |-> (cp_rdata == '0));

  p_unpriv_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (cp_valid && hit_wfar && !cp_priv && !wp_hit) |=> ($stable(wfar_word) && cp_undef));

  p_rx_read_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (cp_valid && hit_xfer && !cp_write && !ext_rx_wr) |=> !rx_full);

  p_reset_quiet_r12: assert property (@(posedge clk)
    !srst_n |-> (!cp_undef && !rx_full && !tx_full && !rx_ovr && !tx_ovr));
endmodule

// File: tb/test_dbg_cop_regs.sv
module test_dbg_cop_regs;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cp_valid, cp_write, cp_priv;
  logic [2:0]  cp_op1, cp_op2;
  logic [3:0]  cp_crn, cp_crm;
  logic [31:0] cp_wdata, cp_rdata;
  logic        cp_undef;
  logic        ext_rx_wr, ext_tx_rd;
  logic [31:0] ext_rx_data, ext_tx_data;
  logic        rx_full, tx_full, rx_ovr, tx_ovr;
  logic        wp_hit, abort_evt;
  logic [31:0] wp_pc;
  logic [1:0]  isa_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cop_regs i_dbg_cop_regs (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [31:0] m_rx, m_tx, m_wfar, m_rdata;
  bit m_rx_f, m_tx_f, m_rx_o, m_tx_o, m_undef;
  bit k_rx, k_tx, k_wfar, k_rdata;
  string tag;

  function automatic logic [31:0] offs(input logic [1:0] s);
    return (s == 2'b01) ? 32'd4 : (s == 2'b10) ? 32'd0 : 32'd8;
  endfunction

  function automatic bit sel_ok(input logic [3:0] crm);
    return cp_op1 == 3'd0 && cp_crn == 4'd0 && cp_op2 == 3'd0 && cp_crm == crm;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic idle_inputs();
    cp_valid = 0; cp_write = 0; cp_priv = 0;
    cp_op1 = 0; cp_crn = 0; cp_crm = 0; cp_op2 = 0; cp_wdata = 0;
    ext_rx_wr = 0; ext_rx_data = 0; ext_tx_rd = 0;
    wp_hit = 0; wp_pc = 0; isa_state = 0; abort_evt = 0;
  endtask

  // advance model with the inputs currently applied, then clock and compare
  task automatic step();
    bit ax, aw, txw, rxr;
    logic [31:0] nr;
    bit nu, nk;
    ax  = cp_valid && sel_ok(4'd5);
    aw  = cp_valid && sel_ok(4'd6);
    txw = ax && cp_write;
    rxr = ax && !cp_write;
    nr = 0; nu = 0; nk = 1;
    if (rxr) begin nr = m_rx; nk = k_rx; end
    else if (aw && cp_priv && !cp_write) begin nr = m_wfar; nk = k_wfar; end
    if (cp_valid && !ax && !(aw && cp_priv)) nu = 1;
    // transmit side
    if (txw && m_tx_f) m_tx_o = 1;
    if (txw && !m_tx_f) begin m_tx = cp_wdata; k_tx = 1; m_tx_f = 1; end
    else if (ext_tx_rd) m_tx_f = 0;
    // receive side
    if (ext_rx_wr && m_rx_f) m_rx_o = 1;
    if (ext_rx_wr && !m_rx_f) begin m_rx = ext_rx_data; k_rx = 1; m_rx_f = 1; end
    else if (rxr) m_rx_f = 0;
    // watchpoint register
    if (wp_hit) begin m_wfar = wp_pc + offs(isa_state); k_wfar = 1; end
    else if (aw && cp_priv && cp_write) begin m_wfar = cp_wdata; k_wfar = 1; end
    m_rdata = nr; m_undef = nu; k_rdata = nk;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rdata"}, k_rdata ? cp_rdata : 32'h0, k_rdata ? m_rdata : 32'h0);
    chk({tag, " undef"}, {31'd0, cp_undef}, {31'd0, m_undef});
    chk("R4 rx_full", {31'd0, rx_full}, {31'd0, m_rx_f});
    chk("R2 tx_full", {31'd0, tx_full}, {31'd0, m_tx_f});
    chk("R5 ovr", {30'd0, rx_ovr, tx_ovr}, {30'd0, m_rx_o, m_tx_o});
    if (k_tx) chk("R2 ext_tx_data", ext_tx_data, m_tx);
  endtask

  task automatic acc(input string t, input bit wr, input bit pv, input logic [3:0] crm,
                     input logic [31:0] d);
    idle_inputs();
    tag = t;
    cp_valid = 1; cp_write = wr; cp_priv = pv; cp_crm = crm; cp_wdata = d;
    step();
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0C14));
    idle_inputs();
    tag = "R12";
    m_rx_f = 0; m_tx_f = 0; m_rx_o = 0; m_tx_o = 0; m_undef = 0;
    k_rx = 0; k_tx = 0; k_wfar = 0; k_rdata = 1; m_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset rdata", cp_rdata, 32'h0);
    chk("R12 reset flags", {27'd0, cp_undef, rx_full, tx_full, rx_ovr, tx_ovr}, 32'h0);
    rst_n = 1;
    repeat (4) step();

    // R2 / R5: outbound write, then overrun
    acc("R2", 1, 0, 4'd5, 32'hCAFE_0001);
    acc("R5", 1, 0, 4'd5, 32'hDEAD_0002);
    // R4: debugger consumes outbound word
    idle_inputs(); tag = "R4"; ext_tx_rd = 1; step();
    acc("R2", 1, 1, 4'd5, 32'h1234_5678);
    // R4 / R5: inbound write and overrun
    idle_inputs(); tag = "R4"; ext_rx_wr = 1; ext_rx_data = 32'hA5A5_0003; step();
    idle_inputs(); tag = "R5"; ext_rx_wr = 1; ext_rx_data = 32'h0BAD_0004; step();
    // R3: core reads inbound, clears flag
    acc("R3", 0, 0, 4'd5, 32'h0);
    // R6: privileged write and read back
    acc("R6", 1, 1, 4'd6, 32'h8000_1000);
    acc("R6", 0, 1, 4'd6, 32'h0);
    // R7: unprivileged write is dropped, read returns zero
    acc("R7", 1, 0, 4'd6, 32'hFFFF_FFFF);
    acc("R7", 0, 0, 4'd6, 32'h0);
    acc("R6", 0, 1, 4'd6, 32'h0);
    // R8: every isa_state code
    for (int s = 0; s < 4; s++) begin
      idle_inputs(); tag = "R8"; wp_hit = 1; wp_pc = 32'h0000_4000 + 32'(s * 16);
      isa_state = 2'(s); step();
      acc("R8", 0, 1, 4'd6, 32'h0);
    end
    // R9: capture beats software write
    idle_inputs(); tag = "R9";
    cp_valid = 1; cp_write = 1; cp_priv = 1; cp_crm = 4'd6; cp_wdata = 32'h1111_1111;
    wp_hit = 1; wp_pc = 32'h2000_0000; isa_state = 2'b01; step();
    acc("R9", 0, 1, 4'd6, 32'h0);
    // R10: abort has no effect
    idle_inputs(); tag = "R10"; abort_evt = 1; step();
    acc("R10", 0, 1, 4'd6, 32'h0);
    // R11: unmatched selectors
    acc("R11", 0, 1, 4'd7, 32'h0);
    idle_inputs(); tag = "R11"; cp_valid = 1; cp_op1 = 3'd1; cp_crm = 4'd5; step();
    idle_inputs(); tag = "R11"; cp_valid = 1; cp_crn = 4'd2; cp_crm = 4'd6; cp_priv = 1; step();
    // R1: back-to-back accesses, each answered on the following edge
    acc("R1", 1, 1, 4'd6, 32'h0F0F_0F0F);
    acc("R1", 0, 1, 4'd6, 32'h0);
    acc("R1", 0, 1, 4'd9, 32'h0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      tag = "R1 rand";
      cp_valid = 1'($urandom_range(0, 1));
      cp_write = 1'($urandom_range(0, 1));
      cp_priv  = ($urandom_range(0, 3) != 0);
      cp_crm   = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'($urandom_range(5, 6));
      if ($urandom_range(0, 15) == 0) cp_op2 = 3'($urandom);
      cp_wdata    = $urandom;
      ext_rx_wr   = ($urandom_range(0, 2) == 0);
      ext_rx_data = $urandom;
      ext_tx_rd   = ($urandom_range(0, 2) == 0);
      wp_hit      = ($urandom_range(0, 7) == 0);
      wp_pc       = $urandom;
      isa_state   = 2'($urandom);
      abort_evt   = ($urandom_range(0, 5) == 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule